// File: doc/BRIEF.md
# ECC Memory Controller Register Block

This block is the software-visible control and status register set of an ECC-protected DRAM controller in a multiprocessor system. It holds nine 32-bit registers in a control window that accepts only word accesses. A second window holds a four-byte diagnostic array that is reached one byte at a time. The error-correction datapath reports faults through a capture port. Each report loads the fault status and fault address registers, and a correctable error can raise a level interrupt. Software clears that interrupt by writing the fault status register.

A build-time parameter `VARIANT` (0, 1 or 2) picks one of three controller generations. The variant sets the version code in the top nibble of the enable register. It also sets which enable bits software may write, which enable bits survive a warm reset, and whether the diagnostic array exists at all. Two synchronous active-high resets are provided. `por` is the power-on reset and sets every register to its initial value. `rst` is the warm reset and lets a variant-specific subset of the enable register survive.

Each read request on either window returns its data one clock later on `rsp_data`, with `rsp_valid` high for that one cycle.

Top module: `memctl_csr`

## Requirements
- R1: After `por`, the delay register (index 1) reads 0x00000020 and fault address 0 (index 4) reads 0x07C00000. The enable register (index 0) reads VARIANT<<28. All other registers read zero and `irq` is low. A warm reset `rst` gives the same values except for the enable register (see R3).
- R2: A word write to the enable register stores (wdata & 0x00000103) for variant 0. For variants 1 and 2 it stores (VARIANT<<28) | (wdata & 0x00000BFF), so the version nibble cannot be changed.
- R3: On `rst`, variant 0 keeps only enable bit 8. Variants 1 and 2 keep bits 31:24, bits 9:2 and bit 11. Every other enable bit clears.
- R4: A write to the delay register stores bits 30:0 only, and bit 31 always reads zero.
- R5: A word write to the fault status register (index 2) stores the written value and drives `irq` low from the next cycle.
- R6: Fault status bits are: bit 0 correctable (CE), bit 3 uncorrectable (UE) and bit 16 multiple errors (ME). When `cap_valid` arrives while CE and UE are both clear, fault status takes `cap_status`, index 4 takes `cap_addr0` and index 5 takes `cap_addr1`.
- R7: When `cap_valid` arrives while CE or UE is already set, only ME is set. Both fault address registers keep their values.
- R8: `irq` rises after a capture whose `cap_status` bit 0 is set, but only when enable bit 0 (ECC on) and enable bit 1 (interrupt on) are both set. Otherwise `irq` is unchanged.
- R9: Word writes to indices 4 and 5 are ignored. Reads of indices 9 to 15 return zero, and writes to those indices have no effect.
- R10: In the control window, a write whose `bus_size` is not word (encoding 0 byte, 1 half, 2 word, 3 reserved) is ignored. A read with such a size returns zero.
- R11: The diagnostic window (`diag_sel`) exists only for variant 0. A byte write stores `bus_wdata[7:0]` at index `bus_addr[1:0]`. A byte read returns that byte in bits 7:0. Accesses that are not byte-sized are ignored and read zero. Variants 1 and 2 always read zero.
- R12: Event count 0 (index 7) and event count 1 (index 8) are separate registers. Each reads back only what was written to it.
- R13: `rsp_valid` is high in exactly the cycle after each read request on either window, and in no other cycle.
- R14: If a capture and a fault status write arrive in the same cycle, the capture sets the fault status. `irq` is set if the capture asserts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Warm reset, synchronous, active high |
| por | input | 1 | Power-on reset, synchronous, active high |
| ctl_sel | input | 1 | Selects the control register window |
| diag_sel | input | 1 | Selects the diagnostic byte window |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the selected window |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data |
| cap_valid | input | 1 | Fault capture strobe |
| cap_status | input | 32 | Fault status word to capture |
| cap_addr0 | input | 32 | First fault address word |
| cap_addr1 | input | 32 | Second fault address word |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | 32 | Read data |
| irq | output | 1 | Correctable-error interrupt, level |

## Verification
The assertions assume that `ctl_sel` and `diag_sel` are never high together. They also assume that a request lasts exactly one cycle. The stimulus meets both: every access task raises a single select for one clock and drops it before the next access. The checks that a fault status write clears the interrupt, and that a fault address write has no effect, are conditioned on there being no capture in the same cycle. The bench keeps captures apart from bus writes, except for the single deliberate collision that exercises the capture-priority rule.

// File: rtl/memctl_csr_pkg.sv
package memctl_csr_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned REG_COUNT   = 9;
    localparam int unsigned IDX_W       = 4;
    localparam int unsigned DIAG_BYTES  = 4;
    localparam int unsigned DIAG_IDX_W  = $clog2(DIAG_BYTES);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [IDX_W-1:0] {
        IDX_ENABLE = 4'd0,
        IDX_DELAY  = 4'd1,
        IDX_FSTAT  = 4'd2,
        IDX_VIDEO  = 4'd3,
        IDX_FADDR0 = 4'd4,
        IDX_FADDR1 = 4'd5,
        IDX_DIAG   = 4'd6,
        IDX_EVCNT0 = 4'd7,
        IDX_EVCNT1 = 4'd8
    } reg_idx_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // fault status bit positions
    localparam int unsigned FS_CE = 0;
    localparam int unsigned FS_UE = 3;
    localparam int unsigned FS_ME = 16;
    // enable bit positions
    localparam int unsigned EN_EE = 0;
    localparam int unsigned EN_EI = 1;

    localparam word_t DELAY_MASK  = 32'h7FFF_FFFF;
    localparam word_t DELAY_INIT  = 32'h0000_0020;
    localparam word_t FADDR0_INIT = 32'h07C0_0000;

    typedef struct packed {
        logic             wr;
        logic             rd;
        logic             rd_ok;
        logic [IDX_W-1:0] idx;
        word_t            wdata;
    } csr_req_t;

    typedef struct packed {
        logic                  wr;
        logic                  rd;
        logic                  rd_ok;
        logic [DIAG_IDX_W-1:0] idx;
        logic [7:0]            wdata;
    } diag_req_t;

    typedef struct packed {
        logic  valid;
        word_t status;
        word_t addr0;
        word_t addr1;
    } fault_cap_t;

    function automatic word_t variant_code(input int unsigned v);
        return word_t'(v) << 28;
    endfunction

    function automatic word_t enable_wr_mask(input int unsigned v);
        return (v == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
    endfunction

    function automatic word_t enable_keep_mask(input int unsigned v);
        return (v == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
    endfunction

    function automatic word_t reset_word(input int unsigned idx);
        case (idx)
            32'(IDX_DELAY):  return DELAY_INIT;
            32'(IDX_FADDR0): return FADDR0_INIT;
            default:         return '0;
        endcase
    endfunction

endpackage

// File: rtl/memctl_csr_decode.sv
module memctl_csr_decode
    import memctl_csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              ctl_sel,
    input  logic              diag_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  word_t             bus_wdata,
    output csr_req_t          csr_req,
    output diag_req_t         diag_req
);
    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] word_idx;
    logic              mapped;
    logic              is_word;
    logic              is_byte;
    logic              diag_only;

    assign word_idx  = bus_addr[ADDR_W-1:2];
    assign mapped    = (32'(word_idx) < REG_COUNT);
    assign is_word   = (acc_size_e'(bus_size) == SZ_WORD);
    assign is_byte   = (acc_size_e'(bus_size) == SZ_BYTE);
    assign diag_only = diag_sel & ~ctl_sel;

    always_comb begin
        csr_req.wr    = ctl_sel & bus_we & is_word & mapped;
        csr_req.rd    = ctl_sel & ~bus_we;
        csr_req.rd_ok = ctl_sel & ~bus_we & is_word & mapped;
        csr_req.idx   = word_idx[IDX_W-1:0];
        csr_req.wdata = bus_wdata;

        diag_req.wr    = diag_only & bus_we & is_byte;
        diag_req.rd    = diag_only & ~bus_we;
        diag_req.rd_ok = diag_only & ~bus_we & is_byte;
        diag_req.idx   = bus_addr[DIAG_IDX_W-1:0];
        diag_req.wdata = bus_wdata[7:0];
    end

endmodule

// File: rtl/memctl_csr_file.sv
module memctl_csr_file
    import memctl_csr_pkg::*;
#(
    parameter int unsigned VARIANT = 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            por,
    input  csr_req_t                        req,
    input  fault_cap_t                      cap,
    output logic [REG_COUNT-1:0][WORD_W-1:0] reg_vec,
    output logic                            irq
);
    localparam word_t CODE  = variant_code(VARIANT);
    localparam word_t WMASK = enable_wr_mask(VARIANT);
    localparam word_t KEEP  = enable_keep_mask(VARIANT);

    word_t regs_q [REG_COUNT];
    word_t regs_d [REG_COUNT];
    logic  irq_q;
    logic  irq_d;
    logic  pending;
    logic  ce_irq;

    assign pending = regs_q[IDX_FSTAT][FS_CE] | regs_q[IDX_FSTAT][FS_UE];
    assign ce_irq  = cap.status[FS_CE] & regs_q[IDX_ENABLE][EN_EE]
                   & regs_q[IDX_ENABLE][EN_EI];

    always_comb begin
        for (int i = 0; i < int'(REG_COUNT); i++) begin
            regs_d[i] = regs_q[i];
        end
        irq_d = irq_q;

        // software write path
        if (req.wr) begin
            case (req.idx)
                IDX_ENABLE: regs_d[IDX_ENABLE] = CODE | (req.wdata & WMASK);
                IDX_DELAY:  regs_d[IDX_DELAY]  = req.wdata & DELAY_MASK;
                IDX_FSTAT: begin
                    regs_d[IDX_FSTAT] = req.wdata;
                    irq_d             = 1'b0;
                end
                IDX_VIDEO:  regs_d[IDX_VIDEO]  = req.wdata;
                IDX_DIAG:   regs_d[IDX_DIAG]   = req.wdata;
                IDX_EVCNT0: regs_d[IDX_EVCNT0] = req.wdata;
                IDX_EVCNT1: regs_d[IDX_EVCNT1] = req.wdata;
                default: ;  // fault address registers are read-only
            endcase
        end

        // fault capture path, takes precedence over the write path
        if (cap.valid) begin
            if (pending) begin
                regs_d[IDX_FSTAT]        = regs_q[IDX_FSTAT];
                regs_d[IDX_FSTAT][FS_ME] = 1'b1;
            end else begin
                regs_d[IDX_FSTAT]  = cap.status;
                regs_d[IDX_FADDR0] = cap.addr0;
                regs_d[IDX_FADDR1] = cap.addr1;
            end
            if (ce_irq) begin
                irq_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (por || rst) begin
            for (int i = 0; i < int'(REG_COUNT); i++) begin
                regs_q[i] <= reset_word(i);
            end
            regs_q[IDX_ENABLE] <= por ? CODE : (regs_q[IDX_ENABLE] & KEEP);
            irq_q              <= 1'b0;
        end else begin
            for (int i = 0; i < int'(REG_COUNT); i++) begin
                regs_q[i] <= regs_d[i];
            end
            irq_q <= irq_d;
        end
    end

    for (genvar g = 0; g < int'(REG_COUNT); g++) begin : g_pack
        assign reg_vec[g] = regs_q[g];
    end

    assign irq = irq_q;

endmodule

// File: rtl/memctl_csr_diag.sv
module memctl_csr_diag
    import memctl_csr_pkg::*;
#(
    parameter int unsigned VARIANT = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      por,
    input  diag_req_t req,
    output logic [7:0] rdata
);
    if (VARIANT == 0) begin : g_array
        logic [7:0] bytes_q [DIAG_BYTES];

        always_ff @(posedge clk) begin
            if (por || rst) begin
                for (int i = 0; i < int'(DIAG_BYTES); i++) begin
                    bytes_q[i] <= '0;
                end
            end else if (req.wr) begin
                bytes_q[req.idx] <= req.wdata;
            end
        end

        assign rdata = bytes_q[req.idx];
    end else begin : g_absent
        logic unused_diag;
        assign unused_diag = ^{clk, rst, por, req};
        assign rdata       = '0;
    end

endmodule

// File: rtl/memctl_csr.sv
module memctl_csr
    import memctl_csr_pkg::*;
#(
    parameter int unsigned VARIANT = 1,
    parameter int unsigned ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              ctl_sel,
    input  logic              diag_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    input  logic              cap_valid,
    input  logic [31:0]       cap_status,
    input  logic [31:0]       cap_addr0,
    input  logic [31:0]       cap_addr1,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              irq
);
    csr_req_t                          csr_req;
    diag_req_t                         diag_req;
    fault_cap_t                        cap;
    logic [REG_COUNT-1:0][WORD_W-1:0]  reg_vec;
    logic [7:0]                        diag_byte;
    word_t                             rd_mux;
    logic                              rsp_valid_q;
    word_t                             rsp_data_q;

    assign cap = '{valid: cap_valid, status: cap_status,
                   addr0: cap_addr0, addr1: cap_addr1};

    memctl_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .ctl_sel   (ctl_sel),
        .diag_sel  (diag_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .csr_req   (csr_req),
        .diag_req  (diag_req)
    );

    memctl_csr_file #(.VARIANT(VARIANT)) u_file (
        .clk     (clk),
        .rst     (rst),
        .por     (por),
        .req     (csr_req),
        .cap     (cap),
        .reg_vec (reg_vec),
        .irq     (irq)
    );

    memctl_csr_diag #(.VARIANT(VARIANT)) u_diag (
        .clk   (clk),
        .rst   (rst),
        .por   (por),
        .req   (diag_req),
        .rdata (diag_byte)
    );

    always_comb begin
        if (csr_req.rd_ok) begin
            rd_mux = reg_vec[csr_req.idx];
        end else if (diag_req.rd_ok) begin
            rd_mux = {24'b0, diag_byte};
        end else begin
            rd_mux = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (por || rst) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= csr_req.rd | diag_req.rd;
            rsp_data_q  <= rd_mux;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/memctl_csr_chk.sv
module memctl_csr_chk #(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              por,
    input logic              ctl_sel,
    input logic              diag_sel,
    input logic              bus_we,
    input logic [ADDR_W-3:0] word_idx,
    input logic [1:0]        bus_size,
    input logic              cap_valid,
    input logic              cap_ce,
    input logic              rsp_valid,
    input logic              irq,
    input logic              en_ee,
    input logic              en_ei,
    input logic              fs_ce,
    input logic              fs_ue,
    input logic              fs_me,
    input logic [31:0]       delay_w,
    input logic [31:0]       faddr0_w
);
    logic rd_req;
    logic fs_wr;
    logic fa_wr;

    assign rd_req = (ctl_sel | diag_sel) & ~bus_we;
    assign fs_wr  = ctl_sel & bus_we & (bus_size == 2'd2) & (32'(word_idx) == 2);
    assign fa_wr  = ctl_sel & bus_we & (bus_size == 2'd2) & (32'(word_idx) == 4);

    assert_init_values_R1: assert property (@(posedge clk) disable iff (rst || por)
        $past(por) |-> (delay_w == 32'h20) && (faddr0_w == 32'h07C0_0000) && !irq);

    assert_rsp_follows_R13: assert property (@(posedge clk) disable iff (rst || por)
        rd_req |=> rsp_valid);

    assert_rsp_only_after_req_R13: assert property (@(posedge clk) disable iff (rst || por)
        rsp_valid |-> $past(rd_req));

    assert_status_write_clears_R5: assert property (@(posedge clk) disable iff (rst || por)
        (fs_wr && !cap_valid) |=> !irq);

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst || por)
        $rose(irq) |-> $past(cap_valid && cap_ce && en_ee && en_ei));

    assert_second_fault_R7: assert property (@(posedge clk) disable iff (rst || por)
        (cap_valid && (fs_ce || fs_ue)) |=> fs_me && $stable(faddr0_w));

    assert_faddr_readonly_R9: assert property (@(posedge clk) disable iff (rst || por)
        (fa_wr && !cap_valid) |=> $stable(faddr0_w));

endmodule

bind memctl_csr memctl_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .por       (por),
    .ctl_sel   (ctl_sel),
    .diag_sel  (diag_sel),
    .bus_we    (bus_we),
    .word_idx  (bus_addr[ADDR_W-1:2]),
    .bus_size  (bus_size),
    .cap_valid (cap_valid),
    .cap_ce    (cap_status[0]),
    .rsp_valid (rsp_valid),
    .irq       (irq),
    .en_ee     (reg_vec[0][0]),
    .en_ei     (reg_vec[0][1]),
    .fs_ce     (reg_vec[2][0]),
    .fs_ue     (reg_vec[2][3]),
    .fs_me     (reg_vec[2][16]),
    .delay_w   (reg_vec[1]),
    .faddr0_w  (reg_vec[4])
);

// File: tb/memctl_csr_test.sv
`timescale 1ns/1ps
module memctl_csr_test;

    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        por = 1'b0;
    logic        ctl_sel = 1'b0;
    logic        diag_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic        cap_valid = 1'b0;
    logic [31:0] cap_status = '0;
    logic [31:0] cap_addr0 = '0;
    logic [31:0] cap_addr1 = '0;

    logic        v1_rsp_valid, v0_rsp_valid;
    logic [31:0] v1_rsp_data, v0_rsp_data;
    logic        v1_irq, v0_irq;

    int tests = 0;
    int fails = 0;

    logic [31:0] exp1_q[$];
    logic [31:0] exp0_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    memctl_csr #(.VARIANT(1), .ADDR_W(6)) uut (
        .clk(clk), .rst(rst), .por(por), .ctl_sel(ctl_sel), .diag_sel(diag_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .cap_valid(cap_valid), .cap_status(cap_status), .cap_addr0(cap_addr0),
        .cap_addr1(cap_addr1), .rsp_valid(v1_rsp_valid), .rsp_data(v1_rsp_data),
        .irq(v1_irq)
    );

    memctl_csr #(.VARIANT(0), .ADDR_W(6)) uut_v0 (
        .clk(clk), .rst(rst), .por(por), .ctl_sel(ctl_sel), .diag_sel(diag_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .cap_valid(cap_valid), .cap_status(cap_status), .cap_addr0(cap_addr0),
        .cap_addr1(cap_addr1), .rsp_valid(v0_rsp_valid), .rsp_data(v0_rsp_data),
        .irq(v0_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data when a response appears
    always @(negedge clk) begin
        if (v1_rsp_valid || v0_rsp_valid) begin
            if (tag_q.size() == 0) begin
                chk("R13 unexpected response", {31'b0, v1_rsp_valid}, 32'd0);
            end else begin
                automatic string       t  = tag_q.pop_front();
                automatic logic [31:0] e1 = exp1_q.pop_front();
                automatic logic [31:0] e0 = exp0_q.pop_front();
                chk({t, " R13 valid v1"}, {31'b0, v1_rsp_valid}, 32'd1);
                chk({t, " R13 valid v0"}, {31'b0, v0_rsp_valid}, 32'd1);
                chk({t, " v1"}, v1_rsp_data, e1);
                chk({t, " v0"}, v0_rsp_data, e0);
            end
        end
    end

    task automatic drive_idle();
        ctl_sel = 1'b0; diag_sel = 1'b0; bus_we = 1'b0; cap_valid = 1'b0;
    endtask

    task automatic ctl_wr(input logic [5:0] a, input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        ctl_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(posedge clk); #1 drive_idle();
    endtask

    task automatic ctl_rd(input logic [5:0] a, input logic [1:0] sz,
                          input logic [31:0] e1, input logic [31:0] e0, input string t);
        @(negedge clk);
        ctl_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
        exp1_q.push_back(e1); exp0_q.push_back(e0); tag_q.push_back(t);
        @(posedge clk); #1 drive_idle();
    endtask

    task automatic diag_wr(input logic [5:0] a, input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        diag_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(posedge clk); #1 drive_idle();
    endtask

    task automatic diag_rd(input logic [5:0] a, input logic [1:0] sz,
                           input logic [31:0] e1, input logic [31:0] e0, input string t);
        @(negedge clk);
        diag_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
        exp1_q.push_back(e1); exp0_q.push_back(e0); tag_q.push_back(t);
        @(posedge clk); #1 drive_idle();
    endtask

    task automatic capture(input logic [31:0] st, input logic [31:0] a0, input logic [31:0] a1);
        @(negedge clk);
        cap_valid = 1'b1; cap_status = st; cap_addr0 = a0; cap_addr1 = a1;
        @(posedge clk); #1 drive_idle();
    endtask

    task automatic irq_chk(input logic e1, input logic e0, input string t);
        @(negedge clk);
        chk({t, " irq v1"}, {31'b0, v1_irq}, {31'b0, e1});
        chk({t, " irq v0"}, {31'b0, v0_irq}, {31'b0, e0});
    endtask

    task automatic pulse_reset(input logic cold);
        @(negedge clk);
        if (cold) por = 1'b1; else rst = 1'b1;
        @(negedge clk);
        por = 1'b0; rst = 1'b0;
    endtask

    localparam logic [1:0] W = 2'd2;
    localparam logic [1:0] H = 2'd1;
    localparam logic [1:0] B = 2'd0;

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        drive_idle();
        pulse_reset(1'b1);
        // R1 reset state
        irq_chk(1'b0, 1'b0, "R1 reset");
        chk("R1 rsp_valid idle", {31'b0, v1_rsp_valid}, 32'd0);
        ctl_rd(6'h00, W, 32'h1000_0000, 32'h0, "R1 enable");
        ctl_rd(6'h04, W, 32'h20, 32'h20, "R1 delay");
        ctl_rd(6'h08, W, 32'h0, 32'h0, "R1 fstat");
        ctl_rd(6'h0C, W, 32'h0, 32'h0, "R1 video");
        ctl_rd(6'h10, W, 32'h07C0_0000, 32'h07C0_0000, "R1 faddr0");
        ctl_rd(6'h14, W, 32'h0, 32'h0, "R1 faddr1");
        ctl_rd(6'h18, W, 32'h0, 32'h0, "R1 diag reg");
        ctl_rd(6'h1C, W, 32'h0, 32'h0, "R1 evcnt0");
        ctl_rd(6'h20, W, 32'h0, 32'h0, "R1 evcnt1");

        // R9 unmapped
        ctl_wr(6'h30, 32'hFFFF_FFFF, W);
        ctl_rd(6'h24, W, 32'h0, 32'h0, "R9 idx9");
        ctl_rd(6'h30, W, 32'h0, 32'h0, "R9 idx12 after write");
        ctl_rd(6'h3C, W, 32'h0, 32'h0, "R9 idx15");

        // R2 enable masking, R4 delay bit 31
        ctl_wr(6'h00, 32'hFFFF_FFFF, W);
        ctl_rd(6'h00, W, 32'h1000_0BFF, 32'h0000_0103, "R2 enable all ones");
        ctl_wr(6'h00, 32'h0000_0400, W);
        ctl_rd(6'h00, W, 32'h1000_0000, 32'h0000_0000, "R2 bit10 masked");
        ctl_wr(6'h00, 32'hFFFF_FFFF, W);
        ctl_wr(6'h04, 32'hFFFF_FFFF, W);
        ctl_rd(6'h04, W, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R4 delay");

        // R3 warm reset
        pulse_reset(1'b0);
        ctl_rd(6'h00, W, 32'h1000_0BFC, 32'h0000_0100, "R3 enable kept");
        ctl_rd(6'h04, W, 32'h20, 32'h20, "R1 delay after rst");

        // R6 / R8 capture with interrupts on
        ctl_wr(6'h00, 32'h0000_0003, W);
        capture(32'h0000_5A31, 32'h1234_5678, 32'h9ABC_DEF0);
        irq_chk(1'b1, 1'b1, "R8 irq enabled");
        ctl_rd(6'h08, W, 32'h0000_5A31, 32'h0000_5A31, "R6 fstat");
        ctl_rd(6'h10, W, 32'h1234_5678, 32'h1234_5678, "R6 faddr0");
        ctl_rd(6'h14, W, 32'h9ABC_DEF0, 32'h9ABC_DEF0, "R6 faddr1");

        // R7 second fault
        capture(32'h0000_0008, 32'h1111_1111, 32'h2222_2222);
        ctl_rd(6'h08, W, 32'h0001_5A31, 32'h0001_5A31, "R7 fstat ME");
        ctl_rd(6'h10, W, 32'h1234_5678, 32'h1234_5678, "R7 faddr0 kept");
        ctl_rd(6'h14, W, 32'h9ABC_DEF0, 32'h9ABC_DEF0, "R7 faddr1 kept");

        // R5 status write clears irq
        ctl_wr(6'h08, 32'h0, W);
        irq_chk(1'b0, 1'b0, "R5 cleared");
        ctl_rd(6'h08, W, 32'h0, 32'h0, "R5 fstat stored");

        // R9 fault address writes ignored
        ctl_wr(6'h10, 32'hDEAD_BEEF, W);
        ctl_wr(6'h14, 32'hDEAD_BEEF, W);
        ctl_rd(6'h10, W, 32'h1234_5678, 32'h1234_5678, "R9 faddr0 ro");
        ctl_rd(6'h14, W, 32'h9ABC_DEF0, 32'h9ABC_DEF0, "R9 faddr1 ro");

        // R8 interrupt disabled
        ctl_wr(6'h00, 32'h0000_0001, W);
        capture(32'h0000_0001, 32'h3333_3333, 32'h4444_4444);
        irq_chk(1'b0, 1'b0, "R8 irq masked");
        ctl_rd(6'h10, W, 32'h3333_3333, 32'h3333_3333, "R6 faddr0 reload");
        ctl_wr(6'h08, 32'h0, W);

        // R12 event counters
        ctl_wr(6'h1C, 32'h0000_AAAA, W);
        ctl_wr(6'h20, 32'h0000_5555, W);
        ctl_rd(6'h1C, W, 32'h0000_AAAA, 32'h0000_AAAA, "R12 evcnt0");
        ctl_rd(6'h20, W, 32'h0000_5555, 32'h0000_5555, "R12 evcnt1");

        // R10 non-word accesses
        ctl_wr(6'h0C, 32'h1234_5678, W);
        ctl_wr(6'h0C, 32'h0000_0077, B);
        ctl_rd(6'h0C, W, 32'h1234_5678, 32'h1234_5678, "R10 byte write ignored");
        ctl_rd(6'h0C, H, 32'h0, 32'h0, "R10 half read zero");

        // R11 diagnostic window
        diag_wr(6'h01, 32'h0000_00C3, B);
        diag_wr(6'h02, 32'h0000_005A, B);
        diag_wr(6'h00, 32'h0000_00EE, W);
        diag_rd(6'h01, B, 32'h0, 32'h0000_00C3, "R11 byte1");
        diag_rd(6'h02, B, 32'h0, 32'h0000_005A, "R11 byte2");
        diag_rd(6'h03, B, 32'h0, 32'h0, "R11 byte3");
        diag_rd(6'h00, B, 32'h0, 32'h0, "R11 word write ignored");
        diag_rd(6'h01, H, 32'h0, 32'h0, "R11 half read zero");

        // R14 capture and status write together
        ctl_wr(6'h00, 32'h0000_0003, W);
        @(negedge clk);
        ctl_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'h08; bus_size = W;
        bus_wdata = 32'h0000_FFFF;
        cap_valid = 1'b1; cap_status = 32'h0000_0001;
        cap_addr0 = 32'hAAAA_0000; cap_addr1 = 32'hBBBB_0000;
        @(posedge clk); #1 drive_idle();
        irq_chk(1'b1, 1'b1, "R14 irq");
        ctl_rd(6'h08, W, 32'h1, 32'h1, "R14 fstat");
        ctl_rd(6'h10, W, 32'hAAAA_0000, 32'hAAAA_0000, "R14 faddr0");

        repeat (4) @(negedge clk);
        chk("R13 outstanding reads", tag_q.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule